// File: doc/BRIEF.md
# Four-Lane Receive Deskew and Alignment Monitor

This block sits after character decoding on a four-lane serial receiver. Each lane delivers one decoded character per clock: a byte, a control flag, a valid strobe, and a lock indication that rises when that lane has finished its synchronisation period. Skew between lanes is not known in advance, so each lane feeds its own small elastic FIFO. A lane starts writing into its FIFO at the alignment marker chosen by a 2-bit select. When all four lanes have started writing, every FIFO begins reading on the same clock. From then on, the four output streams stay in step.

Once the lanes are released, a multiframe position counter runs alongside the output. An alignment marker that leaves the FIFOs at any position other than the last position of the multiframe counts as misplaced. Two misplaced markers in a row on the same lane flush the FIFOs and restart the search. Each lane keeps sticky overflow and underflow flags, which a write-one-to-clear input resets. A manual mode replaces the marker search with a fixed per-lane count of characters to discard.

Top module: `lane_deskew`

## Requirements
- R1: After reset, `aligned`, `realign`, `ovf_err` and `unf_err` are all 0.
- R2: A lane counts alignment markers only in cycles where its `rx_lock` and `rx_valid` are both high. Markers received before lock are ignored.
- R3: The alignment marker is the character 0x7C with `rx_is_k`=1. `cfg_sel_a` picks which locked marker starts the lane: 0 picks the 1st, 1 the 2nd, 2 the 3rd and 3 the 4th.
- R4: `aligned` rises one clock after the cycle in which the last lane presents its selected marker. In that first aligned cycle, each lane's `tx_char`/`tx_is_k` shows that lane's selected marker. Every later cycle shows that lane's next character.
- R5: Each lane FIFO holds 16 characters. Skew of up to 14 cycles between the earliest and latest lane (±7 about the middle) is absorbed with no flag raised.
- R6: At release, the monitor counter sits at `cfg_mf_len`-1. It then advances once per clock and wraps to 0. A marker at the output is expected when the counter is at `cfg_mf_len`-1.
- R7: A single misplaced marker on a lane has no effect. When a lane's next marker at the output is also misplaced, `realign` is high for that cycle. On the following cycle, `aligned` is 0, the FIFOs are empty and the search restarts.
- R8: `ovf_err[l]` sets when lane l writes while its FIFO is full and not reading. `unf_err[l]` sets when the block reads lane l while its FIFO is empty. Both flags are sticky until a 1 on `err_clr[l]`.
- R9: When `cfg_manual`=1, lane l discards its first `cfg_man_dly[4l+3:4l]` locked valid characters and starts writing with the next one. The lanes are released as in R4.
- R10: A control character other than 0x7C, and the byte 0x7C with `rx_is_k`=0, do not count as markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_char | input | 32 | Received byte per lane, lane l in bits [8l+7:8l] |
| rx_is_k | input | 4 | Control-character flag per lane |
| rx_valid | input | 4 | Character valid per lane |
| rx_lock | input | 4 | Lane synchronisation done |
| cfg_sel_a | input | 2 | Which locked marker starts alignment |
| cfg_mf_len | input | 8 | Multiframe length in clocks (at least 1) |
| cfg_manual | input | 1 | Manual delay mode instead of marker search |
| cfg_man_dly | input | 16 | Characters to discard per lane in manual mode |
| err_clr | input | 4 | Write-one-to-clear of lane error flags |
| tx_char | output | 32 | Aligned byte per lane |
| tx_is_k | output | 4 | Aligned control flag per lane |
| aligned | output | 1 | Lanes released and reading together |
| realign | output | 1 | Realignment triggered this cycle |
| ovf_err | output | 4 | Sticky FIFO overflow per lane |
| unf_err | output | 4 | Sticky FIFO underflow per lane |

## Verification
The stimulus covers several cases:
- Each select value, with skew patterns that reach the full 14-cycle spread. A FIFO that is too shallow raises overflow. A design that releases early or late, or that counts the wrong marker, shifts every output byte.
- Decoy characters (another control code, and 0x7C without the control flag) in every stream. A marker decoder that ignores one of the two fields picks the wrong start.
- A lane whose lock arrives after its first marker has passed. Counting markers before lock would start that lane one multiframe early.
- Misplaced markers, once and then twice in a row. Realigning on the first one, or never realigning, shows at `realign` and `aligned`.
- Forced overflow, underflow and the clear pulse, which test the stickiness and the per-lane clear.
- Manual mode, which checks the per-lane discard counts.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

    localparam int CHAR_W = 8;
    localparam logic [CHAR_W-1:0] MARK_BYTE = 8'h7C;

    typedef struct packed {
        logic              is_k;
        logic [CHAR_W-1:0] byte_v;
    } lchar_t;

    function automatic logic is_mark(lchar_t c);
        return c.is_k && (c.byte_v == MARK_BYTE);
    endfunction

endpackage

// File: rtl/lane_buf.sv
module lane_buf
    import lane_align_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             run,
    input  logic             at_last,
    input  lchar_t           in_c,
    input  logic             in_valid,
    input  logic             in_lock,
    input  logic [1:0]       sel_a,
    input  logic             manual,
    input  logic [DLY_W-1:0] man_dly,
    input  logic             err_clr,
    output logic             armed,
    output lchar_t           head,
    output logic             head_is_a,
    output logic             realign_req,
    output logic             ovf_err,
    output logic             unf_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    lchar_t           mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic [2:0]       a_seen;
    logic [DLY_W-1:0] dly_cnt;
    logic             miss;
    logic             seen, mark_in, hit, wr_en, rd_en, full, empty, push, pop;

    always_comb begin
        seen    = in_valid && in_lock;
        mark_in = seen && is_mark(in_c);
        hit     = manual ? (seen && dly_cnt == man_dly)
                         : (mark_in && a_seen == {1'b0, sel_a});
        wr_en   = seen && (armed || hit) && !flush;
        rd_en   = run && !flush;
        full    = (cnt == CW'(DEPTH));
        empty   = (cnt == '0);
        pop     = rd_en && !empty;
        push    = wr_en && (!full || pop);
        head      = mem[rp];
        head_is_a = is_mark(head);
        realign_req = run && !empty && head_is_a && !at_last && miss;
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= in_c;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp      <= '0;
            rp      <= '0;
            cnt     <= '0;
            a_seen  <= '0;
            dly_cnt <= '0;
            armed   <= 1'b0;
            miss    <= 1'b0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
            if (!armed) begin
                if (hit) armed <= 1'b1;
                else if (mark_in && !manual) a_seen <= a_seen + 1'b1;
                else if (seen && manual) dly_cnt <= dly_cnt + 1'b1;
            end
            if (run && !empty && head_is_a) miss <= !at_last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_err <= 1'b0;
            unf_err <= 1'b0;
        end else begin
            ovf_err <= (ovf_err && !err_clr) || (wr_en && full && !pop);
            unf_err <= (unf_err && !err_clr) || (rd_en && empty);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_err && !err_clr |=> ovf_err); // R8
    AST_UNF_SET: assert property (@(posedge clk) disable iff (rst)
        rd_en && empty |=> unf_err); // R8
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> !armed && empty); // R7

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl #(
    parameter int NL   = 4,
    parameter int MF_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NL-1:0]   armed,
    input  logic [NL-1:0]   req,
    input  logic [MF_W-1:0] mf_len,
    output logic            run,
    output logic            flush,
    output logic            at_last
);
    logic [MF_W-1:0] mon_cnt;
    logic [MF_W-1:0] last_pos;

    always_comb begin
        run      = &armed;
        flush    = |req;
        last_pos = mf_len - 1'b1;
        at_last  = (mon_cnt == last_pos);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || flush) mon_cnt <= last_pos;
        else if (at_last)         mon_cnt <= '0;
        else                      mon_cnt <= mon_cnt + 1'b1;
    end

    AST_REALIGN_DROPS: assert property (@(posedge clk) disable iff (rst)
        flush |=> !run); // R7
    AST_MON_START: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> at_last); // R6

endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
    import lane_align_pkg::*;
#(
    parameter int NL    = 4,
    parameter int DEPTH = 16,
    parameter int MF_W  = 8,
    parameter int DLY_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NL*CHAR_W-1:0] rx_char,
    input  logic [NL-1:0]        rx_is_k,
    input  logic [NL-1:0]        rx_valid,
    input  logic [NL-1:0]        rx_lock,
    input  logic [1:0]           cfg_sel_a,
    input  logic [MF_W-1:0]      cfg_mf_len,
    input  logic                 cfg_manual,
    input  logic [NL*DLY_W-1:0]  cfg_man_dly,
    input  logic [NL-1:0]        err_clr,
    output logic [NL*CHAR_W-1:0] tx_char,
    output logic [NL-1:0]        tx_is_k,
    output logic                 aligned,
    output logic                 realign,
    output logic [NL-1:0]        ovf_err,
    output logic [NL-1:0]        unf_err
);
    logic [NL-1:0] armed, req, head_a;
    logic          run, flush, at_last;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        lchar_t in_c, hd;
        assign in_c = '{is_k: rx_is_k[l], byte_v: rx_char[l*CHAR_W +: CHAR_W]};
        lane_buf #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_buf (
            .clk(clk), .rst(rst), .flush(flush), .run(run), .at_last(at_last),
            .in_c(in_c), .in_valid(rx_valid[l]), .in_lock(rx_lock[l]),
            .sel_a(cfg_sel_a), .manual(cfg_manual),
            .man_dly(cfg_man_dly[l*DLY_W +: DLY_W]), .err_clr(err_clr[l]),
            .armed(armed[l]), .head(hd), .head_is_a(head_a[l]),
            .realign_req(req[l]), .ovf_err(ovf_err[l]), .unf_err(unf_err[l])
        );
        assign tx_char[l*CHAR_W +: CHAR_W] = hd.byte_v;
        assign tx_is_k[l] = hd.is_k;
    end

    align_ctrl #(.NL(NL), .MF_W(MF_W)) u_ctrl (
        .clk(clk), .rst(rst), .armed(armed), .req(req), .mf_len(cfg_mf_len),
        .run(run), .flush(flush), .at_last(at_last)
    );

    assign aligned = run;
    assign realign = flush;

    AST_RELEASE_ON_MARK: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned) && !cfg_manual |-> &head_a); // R4

endmodule

// File: tb/lane_deskew_tb_top.sv
module lane_deskew_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam logic [1:0]  V_SEL  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1};
    localparam logic [15:0] V_SKEW [NV] = '{16'h0000, 16'h1530, 16'h770E,
                                           16'hE092, 16'h0000, 16'h0004};
    localparam logic [23:0] V_LOCK [NV] = '{24'd0, 24'd0, 24'd0, 24'd0,
                                           {6'd0, 6'd10, 6'd0, 6'd0},
                                           {6'd0, 6'd0, 6'd12, 6'd0}};

    logic        clk = 0, rst = 1;
    logic [31:0] rx_char = '0, tx_char;
    logic [3:0]  rx_is_k = '0, rx_valid = '0, rx_lock = '0, err_clr = '0;
    logic [3:0]  tx_is_k, ovf_err, unf_err;
    logic [1:0]  cfg_sel_a = '0;
    logic [7:0]  cfg_mf_len = 8'd8;
    logic        cfg_manual = 0;
    logic [15:0] cfg_man_dly = '0;
    logic        aligned, realign;

    int checks = 0, errors = 0, wd = 0;
    int skew [4], lockc [4];
    logic [3:0] hold_off = '0, lock_off = '0;
    int inj_lane = -1, inj_a = -1, inj_b = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_deskew dut_i (.*);

    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            errors++;
            $display("FAIL watchdog: got %0d expected < 50000 cycles", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // stream: /A/ at n%8==7, K28.5 at n%8==3, non-K 0x7C at n%8==5 (R10 decoys)
    function automatic logic [8:0] src(int n, int lane);
        if (lane == inj_lane && (n == inj_a || n == inj_b)) return {1'b1, 8'h7C};
        case (n % 8)
            7: return {1'b1, 8'h7C};
            3: return {1'b1, 8'hBC};
            5: return {1'b0, 8'h7C};
            default: return {1'b0, 8'(n)};
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(int c);
        for (int l = 0; l < 4; l++) begin
            logic [8:0] ch;
            logic v;
            v = (c >= skew[l]) && !hold_off[l];
            ch = v ? src(c - skew[l], l) : 9'd0;
            rx_valid[l] = v;
            rx_lock[l]  = (c >= lockc[l]) && !lock_off[l];
            rx_is_k[l]  = ch[8];
            rx_char[l*8 +: 8] = ch[7:0];
        end
    endtask

    task automatic step(int c);
        drive(c);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rx_valid = '0; rx_lock = '0; rx_is_k = '0; rx_char = '0; err_clr = '0;
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    function automatic logic [8:0] tx_lane(int l);
        return {tx_is_k[l], tx_char[l*8 +: 8]};
    endfunction

    task automatic plain_cfg();
        for (int l = 0; l < 4; l++) begin skew[l] = 0; lockc[l] = 0; end
        hold_off = '0; lock_off = '0; inj_lane = -1; inj_a = -1; inj_b = -1;
        cfg_manual = 0; cfg_sel_a = 0; cfg_mf_len = 8'd8;
    endtask

    initial begin
        int first_p, rl_p, mism, errs, rls, again;
        plain_cfg();
        do_reset();
        @(negedge clk);
        check(!aligned && !realign, "R1", "aligned/realign after reset", {aligned, realign}, 0);
        check(ovf_err == 0 && unf_err == 0, "R1", "error flags after reset", {ovf_err, unf_err}, 0);

        // table walk: select values, skews and late locks
        for (int v = 0; v < NV; v++) begin
            int nl [4];
            int rel;
            plain_cfg();
            cfg_sel_a = V_SEL[v];
            rel = 0;
            for (int l = 0; l < 4; l++) begin
                int seen;
                skew[l]  = int'(V_SKEW[v][l*4 +: 4]);
                lockc[l] = int'(V_LOCK[v][l*6 +: 6]);
                seen = 0; nl[l] = -1;
                for (int c = 0; c < 128 && nl[l] < 0; c++) begin
                    logic [8:0] ch;
                    if (c >= skew[l] && c >= lockc[l]) begin
                        ch = src(c - skew[l], l);
                        if (ch == 9'h17C) begin
                            if (seen == int'(V_SEL[v])) begin
                                nl[l] = c - skew[l];
                                if (c > rel) rel = c;
                            end
                            seen++;
                        end
                    end
                end
            end
            do_reset();
            first_p = -1; mism = 0; errs = 0; rls = 0;
            for (int c = 0; c <= rel + 20; c++) begin
                step(c);
                if (aligned && first_p < 0) first_p = c;
                if (c >= rel)
                    for (int l = 0; l < 4; l++)
                        if (tx_lane(l) !== src(nl[l] + c - rel, l)) mism++;
                if (ovf_err != 0 || unf_err != 0) errs++;
                if (realign) rls++;
            end
            check(first_p == rel, "R4", $sformatf("release cycle vec %0d (R2 R3 R10)", v), first_p, rel);
            check(mism == 0, "R4", $sformatf("lane data mismatches vec %0d", v), mism, 0);
            check(errs == 0, "R5", $sformatf("buffer flag cycles vec %0d", v), errs, 0);
            check(rls == 0, "R6", $sformatf("realign count vec %0d", v), rls, 0);
        end

        // R7: one misplaced marker is tolerated
        plain_cfg(); inj_lane = 1; inj_a = 16;
        do_reset();
        rls = 0; mism = 0;
        for (int c = 0; c <= 45; c++) begin
            step(c);
            if (realign) rls++;
            if (c >= 7 && !aligned) mism++;
        end
        check(rls == 0, "R7", "realign after single misplaced marker", rls, 0);
        check(mism == 0, "R7", "cycles not aligned after single miss", mism, 0);

        // R7: two misplaced markers in a row trigger realignment
        plain_cfg(); inj_lane = 1; inj_a = 24; inj_b = 25;
        do_reset();
        rl_p = -1; again = 0; first_p = -1;
        for (int c = 0; c <= 45; c++) begin
            step(c);
            if (realign && rl_p < 0) rl_p = c;
            if (c == 26) first_p = aligned;
            if (c > 26 && aligned) again = 1;
        end
        check(rl_p == 25, "R7", "realign cycle after second miss", rl_p, 25);
        check(first_p == 0, "R7", "aligned after realign", first_p, 0);
        check(again == 1, "R7", "re-alignment after restart", again, 1);

        // R8: overflow with one lane never locked, then per-lane clear
        plain_cfg(); lock_off = 4'b1000;
        do_reset();
        mism = 0;
        for (int c = 0; c <= 29; c++) begin
            step(c);
            if (aligned) mism++;
        end
        check(mism == 0, "R4", "release with an unlocked lane", mism, 0);
        check(ovf_err == 4'b0111, "R8", "overflow flags", ovf_err, 4'b0111);
        check(unf_err == 4'b0000, "R8", "underflow flags without reads", unf_err, 0);
        hold_off = 4'hF; err_clr = 4'b0001;
        step(30);
        err_clr = 4'b0000;
        step(31);
        check(ovf_err == 4'b0110, "R8", "overflow flags after clearing lane 0", ovf_err, 4'b0110);

        // R8: underflow on lane 2 after a one-cycle gap
        plain_cfg();
        do_reset();
        for (int c = 0; c <= 14; c++) begin
            hold_off = (c == 12) ? 4'b0100 : 4'b0000;
            step(c);
            if (c == 12) check(unf_err == 4'b0000, "R8", "underflow flag before empty read", unf_err, 0);
            if (c == 13) check(unf_err == 4'b0100, "R8", "underflow flag after empty read", unf_err, 4'b0100);
        end
        step(15);
        check(unf_err == 4'b0100, "R8", "underflow flag stays set", unf_err, 4'b0100);

        // R9: manual per-lane discard counts 3,0,5,1
        plain_cfg(); cfg_manual = 1; cfg_man_dly = {4'd1, 4'd5, 4'd0, 4'd3};
        do_reset();
        first_p = -1; mism = 0;
        for (int c = 0; c <= 6; c++) begin
            step(c);
            if (aligned && first_p < 0) first_p = c;
            if (c >= 5)
                for (int l = 0; l < 4; l++)
                    if (tx_lane(l) !== src(int'(cfg_man_dly[l*4 +: 4]) + c - 5, l)) mism++;
        end
        check(first_p == 5, "R9", "manual release cycle", first_p, 5);
        check(mism == 0, "R9", "manual lane data mismatches", mism, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule